// File: doc/BRIEF.md
# Byte-Addressed SRAM Controller with Posted Write Buffer

This block sits between a 32-bit request/ready bus and a word-wide synchronous SRAM array, and serves byte, halfword and word reads and writes. Every write is parked in a one-entry buffer that holds the word index, a byte-enable mask and the lane data. The previous entry goes into the array in the same cycle that the next write arrives. Writes therefore never wait, and the array always trails the bus by exactly one write.

A read of the word held in the buffer gets the buffered bytes laid over the array bytes, so software sees its own writes at once. The buffer's valid bit is cleared by reset. A write still parked at reset never reaches the array. To make a write durable, software either repeats it, follows it with any other write, or pulses `flush` before reset or low-power entry. The array is a behavioural model inside the block, and its depth is set by `DEPTH`.

Top module: `sram_posted`

## Requirements
- R1: Encodings: `size` 2'b00 is byte, 2'b01 is halfword, and 2'b1x is word. Write data is taken right-aligned from `wdata`, and only the byte lanes of the addressed unit change. The other lanes of the word keep their values.
- R2: A word access ignores `addr[1:0]` and a halfword access ignores `addr[0]`. Each always touches the naturally aligned unit.
- R3: A read accepted at a clock edge raises `rvalid` for exactly one cycle after that edge. `rdata` returns the unit right-aligned and zero-extended, so bits above the access size are 0. No `rvalid` appears without an accepted read.
- R4: With `flush` low, `ready` is high every cycle, so back-to-back writes are each accepted with no stall.
- R5: An accepted write is held in the buffer. The array receives it only when the next write is accepted or a flush occurs.
- R6: Reset clears the buffer. A write still pending at reset is lost, and the array keeps its earlier value.
- R7: A read of the buffered word returns the buffered bytes under the buffered byte enables, merged over the array bytes.
- R8: While `flush` is high, `ready` is low and no request is accepted. A pending entry is committed to the array during that cycle.
- R9: Writing a location twice, or issuing any further write after it, makes the data survive a later reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| addr | input | AW | Byte address |
| wdata | input | 32 | Right-aligned write data |
| flush | input | 1 | Commit the buffered write with no new write |
| ready | output | 1 | Request accepted when high together with `req` |
| rvalid | output | 1 | Read data valid |
| rdata | output | 32 | Right-aligned, zero-extended read data |

## Verification
The hardest state to observe is what the array itself holds, because every read is masked by forwarding from the buffer. The only port-level way to see the array is to place a reset between a write and the read that follows it. The stimulus does this in four ways: a value committed by an identical second write, a value committed by a dummy write to another word, a value committed by `flush`, and a newer value left pending. In each case the read after reset must return the committed value and never the pending one. Forwarding of partial writes is reached by laying byte and halfword writes over a word committed just before.

// File: rtl/sram_posted.sv
module sram_posted #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          flush,
  output logic          ready,
  output logic          rvalid,
  output logic [31:0]   rdata
);
  localparam int IW = AW - 2;

  logic [31:0]   mem [DEPTH];
  logic          bv;
  logic [IW-1:0] bidx;
  logic [3:0]    bbe;
  logic [31:0]   bd;
  logic [31:0]   rd_q, fwd;
  logic [3:0]    fwbe, be_in;
  logic [1:0]    roff, rsz;
  logic [31:0]   wlane, merged, shifted;
  logic [4:0]    shamt;

  wire [IW-1:0] idx    = addr[AW-1:2];
  wire          acc    = req & ready;
  wire          wr     = acc & we;
  wire          rd     = acc & ~we;
  wire          commit = bv & (wr | flush);

  assign ready = ~flush;

  always_comb begin
    if (size[1])      be_in = 4'hF;
    else if (size[0]) be_in = addr[1] ? 4'hC : 4'h3;
    else              be_in = 4'b0001 << addr[1:0];
  end

  assign wlane = size[1] ? wdata : size[0] ? {2{wdata[15:0]}} : {4{wdata[7:0]}};

  always_ff @(posedge clk) begin
    if (commit)
      for (int i = 0; i < 4; i++)
        if (bbe[i]) mem[bidx][8*i +: 8] <= bd[8*i +: 8];
    if (rd) begin
      rd_q <= mem[idx];
      fwbe <= (bv && bidx == idx) ? bbe : 4'h0;
      fwd  <= bd;
      roff <= addr[1:0];
      rsz  <= size;
    end
    if (wr) begin
      bidx <= idx;
      bbe  <= be_in;
      bd   <= wlane;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bv     <= 1'b0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (wr)         bv <= 1'b1;
      else if (flush) bv <= 1'b0;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign merged[8*g +: 8] = fwbe[g] ? fwd[8*g +: 8] : rd_q[8*g +: 8];
  end

  assign shamt   = rsz[0] ? {roff[1], 4'b0000} : {roff, 3'b000};
  assign shifted = merged >> shamt;
  assign rdata   = rsz[1] ? merged :
                   rsz[0] ? {16'h0, shifted[15:0]} : {24'h0, shifted[7:0]};
endmodule

// File: rtl/sram_posted_chk.sv
module sram_posted_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          we,
  input logic [1:0]    size,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          flush,
  input logic          ready,
  input logic          rvalid,
  input logic [31:0]   rdata
);
  assert_read_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && !we) |=> rvalid);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && ready && !we) |=> !rvalid);

  assert_byte_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && !we && size == 2'b00) |=> (rdata[31:8] == 24'h0));

  assert_nostall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && !flush) |-> ready);

  assert_flush_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rvalid);

  assert_fwd_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && !we && size[1] && $past(rst_n) &&
     $past(req && ready && we && size[1]) &&
     addr[AW-1:2] == $past(addr[AW-1:2]))
    |=> (rdata == $past(wdata, 2)));
endmodule

bind sram_posted sram_posted_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_sram_posted.sv
module tb_sram_posted;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, flush = 1'b0;
  logic [1:0]    size = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          ready, rvalid;
  logic [31:0]   rdata;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] q_exp [$];
  string       q_tag [$];

  sram_posted #(.DEPTH(256)) dut (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (q_exp.size() == 0) check(1'b0, "R3/R8 unexpected rvalid", rdata, 32'h0);
      else begin
        automatic logic [31:0] e = q_exp.pop_front();
        automatic string t = q_tag.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; size = s; wdata = d;
    #1 check(ready === 1'b1, "R4 ready during write", {31'h0, ready}, 32'h1);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] s, input logic [31:0] e, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; size = s;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk); req = 1'b0; we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); req = 1'b0; we = 1'b0; rst_n = 1'b0;
    #1 check(ready === 1'b1 && rvalid === 1'b0, "R6 reset state", {30'h0, ready, rvalid}, 32'h2);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1 check(rvalid === 1'b0, "R3 rvalid low in reset", {31'h0, rvalid}, 32'h0);
    check(ready === 1'b1, "R4 ready in reset", {31'h0, ready}, 32'h1);
    @(negedge clk); rst_n = 1'b1;

    // R7 and R2: partial writes merged over a committed word
    wr(10'h010, 2'b10, 32'h11223344);
    wr(10'h011, 2'b00, 32'h000000AA);
    rd(10'h010, 2'b10, 32'h1122AA44, "R7 word read merges buffered byte");
    rd(10'h013, 2'b00, 32'h00000011, "R3 byte read zero-extended");
    rd(10'h012, 2'b01, 32'h00001122, "R3 halfword read");
    rd(10'h013, 2'b01, 32'h00001122, "R2 halfword ignores addr bit 0");
    rd(10'h012, 2'b10, 32'h1122AA44, "R2 word ignores addr bits 1:0");
    rd(10'h011, 2'b00, 32'h000000AA, "R7 byte forwarded from buffer");
    wr(10'h016, 2'b01, 32'h0000BEEF);
    rd(10'h016, 2'b01, 32'h0000BEEF, "R1 halfword write");
    rd(10'h017, 2'b00, 32'h000000BE, "R1 byte of halfword");
    rd(10'h010, 2'b10, 32'h1122AA44, "R5 byte committed by next write");
    idle(2);

    // R8: flush commits, and a read during flush is not accepted
    wr(10'h030, 2'b10, 32'hCAFEF00D);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 10'h010; size = 2'b10; flush = 1'b1;
    #1 check(ready === 1'b0, "R8 ready low during flush", {31'h0, ready}, 32'h0);
    @(negedge clk); flush = 1'b0; req = 1'b0;
    idle(1);
    do_reset();
    rd(10'h030, 2'b10, 32'hCAFEF00D, "R8 flushed write survives reset");
    idle(1);

    // R6 and R9: repeated write is durable, the newest pending one is lost
    wr(10'h040, 2'b10, 32'hAAAAAAAA);
    wr(10'h040, 2'b10, 32'hAAAAAAAA);
    wr(10'h040, 2'b10, 32'h55555555);
    do_reset();
    rd(10'h040, 2'b10, 32'hAAAAAAAA, "R6 pending write dropped, R9 double write kept");
    idle(1);

    // R9: a dummy write elsewhere makes the previous write durable
    wr(10'h050, 2'b10, 32'h12345678);
    wr(10'h054, 2'b10, 32'h00000000);
    do_reset();
    rd(10'h050, 2'b10, 32'h12345678, "R9 dummy write commits previous");
    idle(1);

    // R4 and R1: back-to-back writes, then a halfword laid over one word
    for (int i = 0; i < 4; i++)
      wr(10'h060 + 10'(4*i), 2'b10, 32'h01020304 + 32'h10101010 * i);
    wr(10'h062, 2'b01, 32'h00007777);
    rd(10'h060, 2'b10, 32'h77770304, "R1 upper half replaced, lower kept");
    rd(10'h060, 2'b01, 32'h00000304, "R1 untouched lanes");
    rd(10'h063, 2'b00, 32'h00000077, "R7 forwarded byte lane");
    rd(10'h064, 2'b10, 32'h11121314, "R4 back-to-back write 1");
    rd(10'h068, 2'b10, 32'h21222324, "R4 back-to-back write 2");
    rd(10'h06C, 2'b10, 32'h31323334, "R5 committed by halfword write");
    idle(4);

    check(q_exp.size() == 0, "R3 all reads answered", q_exp.size(), 32'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule